// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the status word that a parallel NOR-style flash model returns on reads while one of its internal algorithms (word program, sector erase, buffered write) is running or suspended, together with an active-low ready/busy indication. It also provides a select signal that tells the read path to return cell-array contents instead of status.

The command decoder and the algorithm sequencer sit outside the block. They present the current operation as a 3-bit mode code, plus the sector that is being worked on or is suspended, and bit 7 of the word being programmed. They also raise one-cycle pulses when an algorithm runs past its time limit or a buffered write is aborted. The read path supplies the sector address of each read and a strobe that marks every status read. The two toggle bits advance on those strobes.

All mode, sector and data inputs are registered, so every output follows its inputs one clock later. The read sector address is compared combinationally against the registered operation sector.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, the outputs are `array_sel`=1, `ready`=1 and `stat_word`=0. Strobes during reset have no effect, and both toggle bits restart at 0.
- R2: Mode codes are 0 array read, 1 program, 2 erase, 3 erase-suspend read, 4 program-suspend read, 5 program inside erase suspend, 6 buffered write, and 7 unused. The outputs reflect the mode one clock after it is applied. Code 0 or code 7 gives `array_sel`=1, `ready`=1 and `stat_word`=0, so returning to code 0 when an operation ends shows array data and ready on the next clock. Whenever `array_sel`=1, `stat_word` is 0.
- R3: `stat_word` uses bit 7 DQ7, bit 6 DQ6, bit 5 DQ5, bit 3 DQ3, bit 2 DQ2 and bit 1 DQ1; bits 4 and 0 are 0. In program mode: DQ7 = inverted `prog_d7`, DQ6 = toggle, DQ5 = timeout flag, DQ3 = DQ2 = DQ1 = 0, `ready`=0, `array_sel`=0.
- R4: In erase mode: DQ7=0, DQ6 = toggle, DQ5 = timeout flag, DQ3=1, DQ2 = second toggle, DQ1=0, `ready`=0, `array_sel`=0.
- R5: In erase-suspend read with `rd_sector` equal to the suspended sector: DQ7=1, DQ6 holds its value, DQ5=0, DQ3=0, DQ2 = second toggle, DQ1=0, `ready`=1, `array_sel`=0.
- R6: In erase-suspend read or program-suspend read with `rd_sector` different from the operation sector: `array_sel`=1 and `ready`=1.
- R7: In program-suspend read with `rd_sector` equal to the suspended sector, the read is not allowed: `stat_word`=0, `array_sel`=0, `ready`=1.
- R8: In program inside erase suspend: DQ7 = inverted `prog_d7`, DQ6 = toggle, DQ5 = timeout flag, DQ3 = DQ2 = DQ1 = 0, `ready`=0.
- R9: In buffered-write mode the pattern matches program mode, except that DQ1 is the abort flag. The flag is set by `buf_abort` in that mode, stays set while the mode stays 6, and is cleared by any other mode.
- R10: The timeout flag is set by `time_exceeded` in modes 1, 2, 5 and 6 and is ignored in all other modes. It stays set until mode 0 (or 7) is applied. It is shown on DQ5 only in modes 1, 2, 5 and 6.
- R11: DQ6 toggles on each rising edge of `rd_strobe` taken in modes 1, 2, 5 and 6; in all other modes it holds its value.
- R12: DQ2 toggles on each rising edge of `rd_strobe` taken in mode 2 or 3 while `rd_sector` equals `op_sector`; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Current operation code (see R2) |
| op_sector | input | SECT_W | Sector being programmed, erased or suspended |
| rd_sector | input | SECT_W | Sector address of the current read |
| rd_strobe | input | 1 | High during a status read; each rising edge counts as one read |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| time_exceeded | input | 1 | Pulse: the running algorithm passed its time limit |
| buf_abort | input | 1 | Pulse: the buffered write was aborted |
| stat_word | output | 8 | Status word |
| ready | output | 1 | 1 = ready, 0 = busy |
| array_sel | output | 1 | 1 = the read path returns array data |

## Verification
The bench sweeps all eight mode codes. Within each mode it crosses a read sector that matches the operation sector against one that does not, and bit 7 low against bit 7 high. Across these reads it separates the per-mode bit patterns, the sector-dependent choice between status and array data, and the inverted-data bit. Strobe pulses within each mode show which toggle bit advances and which holds. Separate sequences apply the timeout and abort pulses in modes that accept them and in modes that must ignore them, and assert reset in the middle of an erase with strobes running, which tells sticky and cleared flags apart.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

   typedef enum logic [2:0] {
      MD_ARRAY    = 3'd0,
      MD_PROGRAM  = 3'd1,
      MD_ERASE    = 3'd2,
      MD_ESUSP    = 3'd3,
      MD_PSUSP    = 3'd4,
      MD_ESUSP_PG = 3'd5,
      MD_BUFWR    = 3'd6
   } fst_mode_e;

   localparam int STAT_W = 8;

   // Modes in which an algorithm is actively running
   function automatic logic fst_running(input logic [2:0] m);
      case (m)
         3'd1, 3'd2, 3'd5, 3'd6: fst_running = 1'b1;
         default:                fst_running = 1'b0;
      endcase
   endfunction

   function automatic logic fst_dq2_live(input logic [2:0] m, input logic hit);
      case (m)
         3'd2, 3'd3: fst_dq2_live = hit;
         default:    fst_dq2_live = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/fst_toggle.sv
module fst_toggle #(
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic en_a,
   input  logic en_b,
   output logic tog_a,
   output logic tog_b
);

   logic strobe_q;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   generate
      if (RISE_EDGE) begin : g_rise
         assign hit = strobe & ~strobe_q;
      end else begin : g_fall
         assign hit = ~strobe & strobe_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_a <= 1'b0;
         tog_b <= 1'b0;
      end else begin
         if (hit && en_a) tog_a <= ~tog_a;
         if (hit && en_b) tog_b <= ~tog_b;
      end
   end

endmodule

// File: rtl/fst_event_latch.sv
module fst_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end

endmodule

// File: rtl/fst_pattern.sv
module fst_pattern
   import flash_stat_pkg::*;
(
   input  logic [2:0]        mode,
   input  logic              hit,
   input  logic              d7,
   input  logic              tog6,
   input  logic              tog2,
   input  logic              tmo,
   input  logic              abrt,
   output logic [STAT_W-1:0] stat,
   output logic              rdy,
   output logic              arr
);

   always_comb begin
      stat = '0;
      rdy  = 1'b1;
      arr  = 1'b0;
      case (mode)
         3'd1, 3'd5: begin
            stat[7] = ~d7;
            stat[6] = tog6;
            stat[5] = tmo;
            rdy     = 1'b0;
         end
         3'd2: begin
            stat[6] = tog6;
            stat[5] = tmo;
            stat[3] = 1'b1;
            stat[2] = tog2;
            rdy     = 1'b0;
         end
         3'd3: begin
            if (hit) begin
               stat[7] = 1'b1;
               stat[6] = tog6;
               stat[2] = tog2;
            end else begin
               arr = 1'b1;
            end
         end
         3'd4: arr = ~hit;
         3'd6: begin
            stat[7] = ~d7;
            stat[6] = tog6;
            stat[5] = tmo;
            stat[1] = abrt;
            rdy     = 1'b0;
         end
         default: arr = 1'b1;
      endcase
   end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_stat_pkg::*;
#(
   parameter int SECT_W    = 3,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_mode,
   input  logic [SECT_W-1:0] op_sector,
   input  logic [SECT_W-1:0] rd_sector,
   input  logic              rd_strobe,
   input  logic              prog_d7,
   input  logic              time_exceeded,
   input  logic              buf_abort,
   output logic [7:0]        stat_word,
   output logic              ready,
   output logic              array_sel
);

   generate
      if (SECT_W < 1 || SECT_W > 16) begin : g_bad_width
         $error("flash_status_gen: SECT_W out of range 1..16");
      end
   endgenerate

   logic [2:0]        mode_q;
   logic [SECT_W-1:0] sect_q;
   logic              d7_q;
   logic              tog6, tog2, tmo, abrt;
   logic              in_idle, in_hit, out_hit;

   assign in_idle = (op_mode == MD_ARRAY) || (op_mode == 3'd7);
   assign in_hit  = (rd_sector == op_sector);
   assign out_hit = (rd_sector == sect_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_ARRAY;
         sect_q <= '0;
         d7_q   <= 1'b0;
      end else begin
         mode_q <= op_mode;
         sect_q <= op_sector;
         d7_q   <= prog_d7;
      end
   end

   fst_toggle #(.RISE_EDGE(RISE_EDGE)) i_toggle (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(rd_strobe),
      .en_a  (fst_running(op_mode)),
      .en_b  (fst_dq2_live(op_mode, in_hit)),
      .tog_a (tog6),
      .tog_b (tog2)
   );

   fst_event_latch i_tmo (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (in_idle),
      .set  (time_exceeded && fst_running(op_mode)),
      .flag (tmo)
   );

   fst_event_latch i_abort (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (op_mode != MD_BUFWR),
      .set  (buf_abort),
      .flag (abrt)
   );

   fst_pattern i_pattern (
      .mode(mode_q),
      .hit (out_hit),
      .d7  (d7_q),
      .tog6(tog6),
      .tog2(tog2),
      .tmo (tmo),
      .abrt(abrt),
      .stat(stat_word),
      .rdy (ready),
      .arr (array_sel)
   );

endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
   parameter int SECT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_mode,
   input logic [SECT_W-1:0] op_sector,
   input logic [SECT_W-1:0] rd_sector,
   input logic              rd_strobe,
   input logic              prog_d7,
   input logic              time_exceeded,
   input logic              buf_abort,
   input logic [7:0]        stat_word,
   input logic              ready,
   input logic              array_sel
);

   p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd0) |=> (ready && array_sel && stat_word == 8'h00));

   p_prog_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd1) |=> (!ready && !array_sel && stat_word[7] == !$past(prog_d7)));

   p_erase_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd2) |=> (!ready && stat_word[3] && !stat_word[7]));

   p_abort_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd6 && buf_abort) |=> stat_word[1]);

   p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd2 && time_exceeded) |=> stat_word[5]);

   p_dq6_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd2 && $past(op_mode) == 3'd2 && rd_strobe && !$past(rd_strobe))
      |=> (stat_word[6] != $past(stat_word[6])));

   p_suspend_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 3'd3 && op_sector != rd_sector && $stable(rd_sector))
      |=> (array_sel && ready));

   logic unused_ok;
   assign unused_ok = ^{op_sector, rd_sector};

endmodule

bind flash_status_gen flash_status_chk #(.SECT_W(SECT_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_mode      (op_mode),
   .op_sector    (op_sector),
   .rd_sector    (rd_sector),
   .rd_strobe    (rd_strobe),
   .prog_d7      (prog_d7),
   .time_exceeded(time_exceeded),
   .buf_abort    (buf_abort),
   .stat_word    (stat_word),
   .ready        (ready),
   .array_sel    (array_sel)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;

   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    op_mode = 3'd0;
   logic [SW-1:0] op_sector = '0;
   logic [SW-1:0] rd_sector = '0;
   logic          rd_strobe = 1'b0;
   logic          prog_d7 = 1'b0;
   logic          time_exceeded = 1'b0;
   logic          buf_abort = 1'b0;
   logic [7:0]    stat_word;
   logic          ready;
   logic          array_sel;

   int checks = 0;
   int fails = 0;

   // model state
   int m_mode = 0;
   int m_sec = 0;
   bit m_d7 = 0, m_t6 = 0, m_t2 = 0, m_to = 0, m_ab = 0, m_prev = 0;

   always #5 clk = ~clk;

   flash_status_gen #(.SECT_W(SW)) i_flash_status_gen (
      .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_sector(op_sector),
      .rd_sector(rd_sector), .rd_strobe(rd_strobe), .prog_d7(prog_d7),
      .time_exceeded(time_exceeded), .buf_abort(buf_abort),
      .stat_word(stat_word), .ready(ready), .array_sel(array_sel)
   );

   function automatic bit running(int m);
      return (m == 1 || m == 2 || m == 5 || m == 6);
   endfunction

   // one clock with the current inputs, then advance the model
   task automatic step();
      bit rise, hit;
      @(negedge clk);
      if (!rst_n) begin
         m_mode = 0; m_sec = 0; m_d7 = 0; m_t6 = 0; m_t2 = 0;
         m_to = 0; m_ab = 0; m_prev = 0;
      end else begin
         rise = rd_strobe && !m_prev;
         hit  = (rd_sector == op_sector);
         m_prev = rd_strobe;
         if (rise && running(op_mode)) m_t6 = ~m_t6;
         if (rise && hit && (op_mode == 2 || op_mode == 3)) m_t2 = ~m_t2;
         if (op_mode == 0 || op_mode == 7) m_to = 0;
         else if (time_exceeded && running(op_mode)) m_to = 1;
         if (op_mode != 6) m_ab = 0;
         else if (buf_abort) m_ab = 1;
         m_mode = op_mode; m_sec = op_sector; m_d7 = prog_d7;
      end
   endtask

   task automatic check(string req);
      logic [7:0] es;
      bit er, ea, hit;
      es = 8'h00; er = 1; ea = 0;
      hit = (rd_sector == m_sec);
      case (m_mode)
         1, 5: begin es[7] = ~m_d7; es[6] = m_t6; es[5] = m_to; er = 0; end
         2: begin es[6] = m_t6; es[5] = m_to; es[3] = 1; es[2] = m_t2; er = 0; end
         3: if (hit) begin es[7] = 1; es[6] = m_t6; es[2] = m_t2; end else ea = 1;
         4: ea = !hit;
         6: begin es[7] = ~m_d7; es[6] = m_t6; es[5] = m_to; es[1] = m_ab; er = 0; end
         default: ea = 1;
      endcase
      checks++;
      if (stat_word !== es || ready !== er || array_sel !== ea) begin
         fails++;
         $display("FAIL %s: mode=%0d got stat=%h rdy=%b sel=%b exp stat=%h rdy=%b sel=%b",
                  req, m_mode, stat_word, ready, array_sel, es, er, ea);
      end
   endtask

   function automatic string mode_req(int m, bit hit);
      case (m)
         1: return "R3";
         2: return "R4";
         3: return hit ? "R5" : "R6";
         4: return hit ? "R7" : "R6";
         5: return "R8";
         6: return "R9";
         default: return "R2";
      endcase
   endfunction

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      step();
      check("R1");
      rst_n = 1'b1;
      step();
      check("R1");

      // R2..R9, R11, R12: sweep modes x sector hit x data bit with strobes
      for (int md = 0; md < 8; md++) begin
         for (int hv = 0; hv < 2; hv++) begin
            for (int dv = 0; dv < 2; dv++) begin
               op_mode = md[2:0];
               op_sector = 3'd5;
               rd_sector = hv ? 3'd5 : 3'd2;
               prog_d7 = dv[0];
               rd_strobe = 1'b0;
               step(); check(mode_req(md, hv[0]));
               for (int k = 0; k < 3; k++) begin
                  rd_strobe = 1'b1; step(); check("R11");
                  rd_strobe = 1'b0; step(); check("R12");
               end
               op_mode = 3'd0;
               step(); check("R2");
            end
         end
      end

      // R10: timeout sticky, hidden in suspend, cleared by array read
      op_sector = 3'd1; rd_sector = 3'd1;
      op_mode = 3'd2; step(); check("R10");
      time_exceeded = 1'b1; step(); check("R10");
      time_exceeded = 1'b0; step(); check("R10");
      op_mode = 3'd3; step(); check("R10");
      op_mode = 3'd2; step(); check("R10");
      op_mode = 3'd0; step(); check("R10");
      op_mode = 3'd2; step(); check("R10");
      op_mode = 3'd3; time_exceeded = 1'b1; step(); check("R10");
      time_exceeded = 1'b0;
      op_mode = 3'd2; step(); check("R10");
      op_mode = 3'd6; time_exceeded = 1'b1; step(); check("R10");
      time_exceeded = 1'b0; op_mode = 3'd0; step(); check("R10");

      // R9: abort flag sticky inside buffered write, cleared outside
      op_mode = 3'd6; step(); check("R9");
      buf_abort = 1'b1; step(); check("R9");
      buf_abort = 1'b0; step(); check("R9");
      op_mode = 3'd1; step(); check("R9");
      op_mode = 3'd6; step(); check("R9");
      op_mode = 3'd1; buf_abort = 1'b1; step(); check("R9");
      buf_abort = 1'b0; op_mode = 3'd6; step(); check("R9");

      // R1: reset in the middle of an erase with strobes running
      op_mode = 3'd2; rd_sector = 3'd1; op_sector = 3'd1;
      rd_strobe = 1'b1; step(); check("R1");
      rd_strobe = 1'b0; step(); check("R1");
      rst_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         rd_strobe = 1'b1; step(); check("R1");
         rd_strobe = 1'b0; step(); check("R1");
      end
      rst_n = 1'b1;
      step(); check("R1");
      step(); check("R1");
      op_mode = 3'd0; step(); check("R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule